// File: doc/BRIEF.md
# Programmable Display Sync Counter Bank

This block builds the timing strobes of a raster display from a bank of eight small event counters. Each counter counts the events of a source it selects. The source can be nothing, the pixel clock enable, or the pulse output of a lower-numbered counter. Chaining counters this way turns one pixel-rate enable into an internal line strobe, an external line sync, a frame sync, a line-active window, a pixel-active window and any similar derived waveform.

Each counter has a period, a start offset counted on its own offset source, a repeat limit and a clear source that restarts the offset/repeat sequence. It can also shape its pin output with rise and fall points measured in half-events of a trigger source. A configuration write port programs every counter and the pin polarity mask. All counters are held at their start state while the global enable is low, and they start again from that state when it rises.

The pixel clock is not a clock here. It is a single-cycle enable on the system clock, and counters change only on their source events.

Top module: `disp_sync_bank`

## Requirements
- R1: Source codes are 3 bits. Code 0 selects no event, code 1 selects `pix_en_i`, and code k ≥ 2 selects the pulse of counter k-2 (0-based). A counter pulse is seen as an event by other counters in the cycle after it appears on `pulse_o`. A counter in its run phase never pulses without an event of its run source.
- R2: In its run phase, a counter pulses once on every (run+1)-th event of its run source. The pulse shows on `pulse_o` one cycle after the event cycle.
- R3: With an offset value N > 0, the first pulse after start or clear comes on the N-th event of the offset source, and the run phase follows it. With N = 0, the counter starts directly in its run phase.
- R4: A repeat value R > 0 stops the counter after R pulses, counting the offset pulse. R = 0 lets it run without end.
- R5: An event of the clear source returns the counter to its start state. No pulse is produced on that cycle, and that cycle's events are not counted.
- R6: With shaping enabled, the pin is asserted from the cycle after a pulse event while the half-event position p satisfies rise ≤ p < fall. p is 0 at the pulse and grows by 2 on each trigger-source event, so a width of N events is programmed as fall = 2N.
- R7: Bit i of the polarity mask inverts `pin_o[i]`.
- R8: While `en_i` is low, every counter is held at its start state, with its offset reloaded, and `pulse_o` is 0 from the next cycle. After reset, `pulse_o` and `pin_o` are 0.
- R9: Config writes use `cfg_sel_i`.
  - Select 0 is the timing word: run count [30:19], run source [18:16], offset count [14:3], offset source [2:0].
  - Select 1 is the shape word: shaping enable [31], clear source [29:27], fall [25:16], trigger source [15:13], rise [9:0].
  - Select 2 is the repeat word: repeat [11:0].
  - Select 3 is the polarity mask in [7:0], and `cfg_idx_i` is ignored for it.
  - The other selects write counter `cfg_idx_i`.
- R10: With shaping disabled, a counter's pin follows its pulse, before polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global run enable |
| pix_en_i | input | 1 | Pixel clock enable, one event per high cycle |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | Config word select |
| cfg_idx_i | input | 3 | Counter index for the write |
| cfg_wdata_i | input | 32 | Config write data |
| pulse_o | output | 8 | One pulse per counter |
| pin_o | output | 8 | Shaped and polarity-adjusted pin waveforms |

## Verification
A wrong count, phase or repeat state shows on `pulse_o` as a pulse that is early, late, missing or extra, within one source period. In a chained counter it spreads into every counter that uses that pulse. The bench programs a whole chain and predicts the cycle of every pulse on five counters under two pixel-enable rates. A shaping fault shows within the first trigger events after a pulse as a pin edge in the wrong cycle.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  localparam int CNT_W  = 12;
  localparam int EDGE_W = 10;
  localparam int SRC_W  = 3;
  localparam int POS_W  = EDGE_W + 1;

  localparam int W0_RUN_LSB  = 19;
  localparam int W0_RSRC_LSB = 16;
  localparam int W0_OFF_LSB  = 3;
  localparam int W0_OSRC_LSB = 0;
  localparam int W1_UP_LSB   = 0;
  localparam int W1_TRIG_LSB = 13;
  localparam int W1_DOWN_LSB = 16;
  localparam int W1_CLR_LSB  = 27;
  localparam int W1_GEN_BIT  = 31;

  typedef enum logic [1:0] {
    SEL_TIMING   = 2'd0,
    SEL_SHAPE    = 2'd1,
    SEL_REPEAT   = 2'd2,
    SEL_POLARITY = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    PH_OFFSET = 2'd0,
    PH_RUN    = 2'd1,
    PH_DONE   = 2'd2
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0]  run_cnt;
    logic [SRC_W-1:0]  run_src;
    logic [CNT_W-1:0]  off_cnt;
    logic [SRC_W-1:0]  off_src;
    logic [CNT_W-1:0]  rep_cnt;
    logic [SRC_W-1:0]  clr_src;
    logic [SRC_W-1:0]  trig_src;
    logic [EDGE_W-1:0] up_pt;
    logic [EDGE_W-1:0] down_pt;
    logic              gen_en;
  } ctr_cfg_t;
endpackage

// File: rtl/dsync_cfg_regs.sv
module dsync_cfg_regs
  import dsync_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int IDX_W   = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [1:0]                      sel_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [31:0]                     wdata_i,
  output ctr_cfg_t [NUM_CTR-1:0]          cfg_o,
  output logic [NUM_CTR-1:0]              pol_o
);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g] <= '0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        case (cfg_sel_e'(sel_i))
          SEL_TIMING: begin
            cfg_o[g].run_cnt <= wdata_i[W0_RUN_LSB  +: CNT_W];
            cfg_o[g].run_src <= wdata_i[W0_RSRC_LSB +: SRC_W];
            cfg_o[g].off_cnt <= wdata_i[W0_OFF_LSB  +: CNT_W];
            cfg_o[g].off_src <= wdata_i[W0_OSRC_LSB +: SRC_W];
          end
          SEL_SHAPE: begin
            cfg_o[g].gen_en   <= wdata_i[W1_GEN_BIT];
            cfg_o[g].clr_src  <= wdata_i[W1_CLR_LSB  +: SRC_W];
            cfg_o[g].down_pt  <= wdata_i[W1_DOWN_LSB +: EDGE_W];
            cfg_o[g].trig_src <= wdata_i[W1_TRIG_LSB +: SRC_W];
            cfg_o[g].up_pt    <= wdata_i[W1_UP_LSB   +: EDGE_W];
          end
          SEL_REPEAT: cfg_o[g].rep_cnt <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        pol_o <= '0;
    else if (we_i && cfg_sel_e'(sel_i) == SEL_POLARITY) pol_o <= wdata_i[NUM_CTR-1:0];
  end

endmodule

// File: rtl/dsync_counter.sv
module dsync_counter
  import dsync_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_ev_i,
  input  logic             off_ev_i,
  input  logic             clr_ev_i,
  input  logic [CNT_W-1:0] run_cnt_i,
  input  logic [CNT_W-1:0] off_cnt_i,
  input  logic [CNT_W-1:0] rep_cnt_i,
  output logic             fire_o,
  output logic             pulse_o
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] oc_q, oc_d, rc_q, rc_d, pc_q, pc_d;
  logic             fire;

  always_comb begin
    fire = 1'b0;
    ph_d = ph_q;
    oc_d = oc_q;
    rc_d = rc_q;
    pc_d = pc_q;
    if (!en_i || clr_ev_i) begin
      ph_d = (off_cnt_i == '0) ? PH_RUN : PH_OFFSET;
      oc_d = '0;
      rc_d = '0;
      pc_d = '0;
    end else begin
      case (ph_q)
        PH_OFFSET: if (off_ev_i) begin
          if (oc_q + CNT_W'(1) == off_cnt_i) begin
            fire = 1'b1;
            ph_d = PH_RUN;
            rc_d = '0;
          end else begin
            oc_d = oc_q + CNT_W'(1);
          end
        end
        PH_RUN: if (run_ev_i) begin
          if (rc_q == run_cnt_i) begin
            fire = 1'b1;
            rc_d = '0;
          end else begin
            rc_d = rc_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
      if (fire) begin
        if (rep_cnt_i == '0) begin
          pc_d = '0;
        end else begin
          pc_d = pc_q + CNT_W'(1);
          if (pc_q + CNT_W'(1) == rep_cnt_i) ph_d = PH_DONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_OFFSET;
      oc_q    <= '0;
      rc_q    <= '0;
      pc_q    <= '0;
      pulse_o <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      oc_q    <= oc_d;
      rc_q    <= rc_d;
      pc_q    <= pc_d;
      pulse_o <= fire;
    end
  end

  assign fire_o = fire;

  AST_CLEAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ev_i |=> !pulse_o); // R5
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DONE && !clr_ev_i) |=> !pulse_o); // R4
  AST_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RUN && !run_ev_i) |=> !pulse_o); // R1

endmodule

// File: rtl/dsync_shaper.sv
module dsync_shaper
  import dsync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fire_i,
  input  logic              pulse_i,
  input  logic              trig_ev_i,
  input  logic              gen_en_i,
  input  logic [EDGE_W-1:0] up_i,
  input  logic [EDGE_W-1:0] down_i,
  output logic              pin_o
);

  localparam logic [POS_W-1:0] IDLE = '1;

  logic [POS_W-1:0] pos_q;

  // position in half trigger events since the last pulse; IDLE before any
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pos_q <= IDLE;
    else if (!en_i)                        pos_q <= IDLE;
    else if (fire_i)                       pos_q <= '0;
    else if (trig_ev_i && pos_q != IDLE)
      pos_q <= (pos_q > IDLE - POS_W'(2)) ? IDLE : pos_q + POS_W'(2);
  end

  assign pin_o = gen_en_i ? (pos_q != IDLE && pos_q >= {1'b0, up_i} && pos_q < {1'b0, down_i})
                          : pulse_i;

  AST_EDGE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && gen_en_i && up_i == '0 && down_i != '0 && $rose(pulse_i)) |-> pin_o); // R6

endmodule

// File: rtl/disp_sync_bank.sv
module disp_sync_bank
  import dsync_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int IDX_W   = $clog2(NUM_CTR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               pix_en_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [NUM_CTR-1:0] pulse_o,
  output logic [NUM_CTR-1:0] pin_o
);

  localparam int EV_N = NUM_CTR + 2;

  ctr_cfg_t [NUM_CTR-1:0] cfg;
  logic [NUM_CTR-1:0]     pol, fire, pin_raw;
  logic [EV_N-1:0]        ev_bus;

  dsync_cfg_regs #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .pol_o   (pol)
  );

  // code 0: none, 1: pixel enable, k>=2: registered pulse of counter k-2
  assign ev_bus = {pulse_o, pix_en_i, 1'b0};

  function automatic logic pick_ev(input logic [EV_N-1:0] bus, input logic [SRC_W-1:0] sel);
    pick_ev = (int'(sel) < EV_N) ? bus[sel] : 1'b0;
  endfunction

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ch
    logic run_ev, off_ev, clr_ev, trig_ev;

    always_comb begin
      run_ev  = pick_ev(ev_bus, cfg[g].run_src);
      off_ev  = pick_ev(ev_bus, cfg[g].off_src);
      clr_ev  = pick_ev(ev_bus, cfg[g].clr_src);
      trig_ev = pick_ev(ev_bus, cfg[g].trig_src);
    end

    dsync_counter u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .run_ev_i  (run_ev),
      .off_ev_i  (off_ev),
      .clr_ev_i  (clr_ev),
      .run_cnt_i (cfg[g].run_cnt),
      .off_cnt_i (cfg[g].off_cnt),
      .rep_cnt_i (cfg[g].rep_cnt),
      .fire_o    (fire[g]),
      .pulse_o   (pulse_o[g])
    );

    dsync_shaper u_shp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .fire_i    (fire[g]),
      .pulse_i   (pulse_o[g]),
      .trig_ev_i (trig_ev),
      .gen_en_i  (cfg[g].gen_en),
      .up_i      (cfg[g].up_pt),
      .down_i    (cfg[g].down_pt),
      .pin_o     (pin_raw[g])
    );
  end

  assign pin_o = pin_raw ^ pol;

  AST_ENABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pulse_o == '0)); // R8

endmodule

// File: tb/disp_sync_bank_tb.sv
`timescale 1ns/1ps
module disp_sync_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, pix = 1'b0, we = 1'b0;
  logic [1:0] sel = '0;
  logic [2:0] idx = '0;
  logic [31:0] wdata = '0;
  logic [7:0] pulse, pin;

  int checks = 0, errors = 0, cyc = 0, base = 0;
  bit mon_on = 1'b0, done = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  disp_sync_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pix_en_i(pix),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_idx_i(idx), .cfg_wdata_i(wdata),
    .pulse_o(pulse), .pin_o(pin)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int i);
    case (i)
      0: return "R2";
      1: return "R1";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  // expected pulse cycles relative to the first enabled edge
  function automatic bit exp_hit(int s, int i, int t);
    if (s == 0) begin
      case (i)
        0: return t >= 4 && (t - 4) % 5 == 0;
        1: return t >= 15 && t % 15 == 0;
        2: return t % 5 == 1;
        3: return t == 5 || t == 10 || t == 15;
        default: return t == 1 || t == 2 || t == 8 || t == 9 || t == 13 || t == 14 || t == 18 || t == 19;
      endcase
    end else begin
      case (i)
        0: return t >= 8 && (t - 8) % 10 == 0;
        1: return t == 29;
        2: return t >= 2 && (t - 2) % 10 == 0;
        3: return t == 9 || t == 19 || t == 29;
        default: return t == 2 || t == 4 || t == 14 || t == 16 || t == 24 || t == 26 || t == 34 || t == 36;
      endcase
    end
  endfunction

  // monitor: compare every observed pulse with the next expected item
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 8; i++) begin
        if (pulse[i]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, req_of(i), "unexpected pulse ctr/cycle", i * 1000 + (cyc - base), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(e == cyc * 8 + i, req_of(i), "pulse ctr*1000+cycle",
                i * 1000 + (cyc - base), (e % 8) * 1000 + (e / 8 - base));
          end
        end
      end
    end
  end

  task automatic wr(int i, int s, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; idx = 3'(i); sel = 2'(s); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] w0(int run, int rsrc, int off, int osrc);
    return (32'(run) << 19) | (32'(rsrc) << 16) | (32'(off) << 3) | 32'(osrc);
  endfunction

  function automatic logic [31:0] w1(int gen, int clr, int trig, int down, int up);
    return (32'(gen) << 31) | (32'(clr) << 27) | (32'(down) << 16) | (32'(trig) << 13) | 32'(up);
  endfunction

  task automatic run_scenario(int s);
    @(negedge clk);
    base = cyc + 1;
    for (int t = 0; t <= 40; t++)
      for (int i = 0; i < 5; i++)
        if (exp_hit(s, i, t)) exp_q.push_back((base + t) * 8 + i);
    mon_on = 1'b1;
    for (int k = 0; k <= 41; k++) begin
      int t;
      if (k > 0) @(negedge clk);
      t = k - 1;
      if (s == 0) begin
        if (t == 1 || t == 2) chk(pin[2] == 1'b1, "R6", "shaped pin high", pin[2], 1);
        if (t == 3) chk(pin[2] == 1'b0, "R6", "shaped pin falls after 2 events", pin[2], 0);
        if (t == 4) chk(pin[0] == 1'b1, "R10", "unshaped pin follows pulse", pin[0], 1);
        if (t == 5) chk(pin[0] == 1'b0, "R10", "unshaped pin low after pulse", pin[0], 0);
        if (t == 10) chk(pin[7] == 1'b1, "R7", "inverted idle pin", pin[7], 1);
      end else begin
        if (t == 1) chk(pin[2] == 1'b1, "R7", "inverted pin before first pulse", pin[2], 1);
        if (t >= 2 && t <= 5) chk(pin[2] == 1'b0, "R6", "inverted shaped pin active", pin[2], 0);
        if (t == 6) chk(pin[2] == 1'b1, "R6", "half-event fall at slow rate", pin[2], 1);
      end
      if (k <= 40) begin
        en  = 1'b1;
        pix = (s == 0) ? 1'b1 : (k % 2 == 0);
      end else begin
        en  = 1'b0;
        pix = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    chk(pulse == 8'h00, "R8", "pulses with enable low", pulse, 0);
    mon_on = 1'b0;
    chk(exp_q.size() == 0, "R9", "expected pulses left over", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pulse == 8'h00, "R8", "pulse_o in reset", pulse, 0);
    chk(pin == 8'h00, "R8", "pin_o in reset", pin, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pulse == 8'h00 && pin == 8'h00, "R8", "outputs after reset", {pulse, pin}, 0);
    // R9: program through the config word layout
    wr(0, 0, w0(4, 1, 0, 0));
    wr(1, 0, w0(2, 2, 0, 0));
    wr(2, 0, w0(4, 1, 2, 1));
    wr(2, 1, w1(1, 0, 1, 4, 0));
    wr(3, 0, w0(0, 2, 1, 2));
    wr(3, 2, 32'd3);
    wr(4, 0, w0(0, 1, 2, 1));
    wr(4, 1, w1(0, 5, 0, 0, 0));
    wr(4, 2, 32'd2);
    wr(5, 3, 32'h80);
    repeat (2) @(negedge clk);
    chk(pulse == 8'h00, "R8", "no pulses before enable", pulse, 0);
    chk(pin == 8'h80, "R7", "polarity mask on idle pins", pin, 8'h80);
    run_scenario(0);
    chk(pin == 8'h80, "R8", "pins idle while disabled", pin, 8'h80);
    wr(0, 3, 32'h84);
    repeat (2) @(negedge clk);
    chk(pin == 8'h84, "R7", "new polarity mask", pin, 8'h84);
    run_scenario(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule